// File: doc/BRIEF.md
# Programming Page Buffer and Memory Model

This block is the target side of an in-system programming path. It takes commands that have already been decoded into an opcode, an address and a data byte. It keeps two behavioural non-volatile arrays: a flash array of 16-bit words and a byte-wide EEPROM. Data for both arrays is staged in temporary page buffers. Loading the buffers is cheap. A commit command moves the staged data into the array and starts a busy period.

Each byte position in the page buffers has its own "loaded" bit. A flash commit writes the whole page. Words that were loaded take the staged value and all other words take the erased value. An EEPROM commit writes only the bytes that were loaded and leaves the rest of the page untouched. The block also provides single-byte EEPROM writes, a whole-device erase, read-back of both arrays and a busy poll. A command other than a poll that arrives during a busy period is dropped and reported on a violation pulse.

Top module: `prog_page_store`

## Requirements
- R1: After reset, busy, rsp_valid and busy_violation are 0, and every location of both arrays reads 0xFF.
- R2: Opcode 1 stages the low byte and opcode 2 stages the high byte of the flash word selected by cmd_addr[4:0]. A high-byte load is ignored if that word's low byte has not been staged since the last commit or erase.
- R3: Opcode 3 commits the flash buffer to the page selected by cmd_addr[10:5]. A word whose low byte was staged takes {high, low}, where the high byte is 0xFF if it was never staged. Every other word of the page becomes 0xFFFF. All loaded bits are then cleared.
- R4: Opcode 4 stages a byte at EEPROM buffer index cmd_addr[1:0]. Opcode 5 commits to the page selected by cmd_addr[7:2] and changes only the staged bytes. The loaded bits are cleared after each commit, so a later commit with nothing staged changes nothing.
- R5: Opcode 6 writes cmd_data to EEPROM address cmd_addr[7:0] as an erase followed by a write. The new byte fully replaces the old one, and bits can go from 0 to 1.
- R6: Opcode 7 reads the flash word at cmd_addr[10:0]: the high byte if cmd_data[0] is 1, otherwise the low byte. Opcode 8 reads EEPROM address cmd_addr[7:0]. rsp_valid is high for one cycle, one clock after the command, with the byte on rsp_data.
- R7: Opcode 9 (poll) is answered one clock later with rsp_data[0] equal to busy as it was when the command was sampled, and bits 7:1 equal to 0. A poll is accepted even while busy.
- R8: A flash commit or an erase holds busy high for exactly FL_BUSY_CYCLES clocks. An EEPROM commit or byte write holds it high for exactly EE_BUSY_CYCLES clocks. Busy is visible from the clock after the command.
- R9: Any command other than a poll that arrives while busy has no effect on any array or buffer and gives no response. busy_violation is 1 for the following cycle.
- R10: Opcode 10 sets every location of both arrays to 0xFF and clears all loaded bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | 8 | Command data byte |
| rsp_valid | output | 1 | Read or poll response valid |
| rsp_data | output | 8 | Response byte |
| busy | output | 1 | Write in progress |
| busy_violation | output | 1 | Pulse: a non-poll command arrived while busy |

## Verification
The bench keeps the default geometry of 32-word flash pages, 64 flash pages and 4-byte EEPROM pages. It shortens the busy times to 12 and 5 cycles. With these times, the exact busy length can be counted for both memories, and a command can be placed inside a busy window to show that it is dropped. Random traffic is confined to a few pages, so commits often land on pages that already hold data. This exercises the masked EEPROM commit and the flash fill of unloaded words against previous contents.

// File: rtl/prog_page_pkg.sv
package prog_page_pkg;
   typedef enum logic [3:0] {
      OP_NONE      = 4'd0,
      OP_FL_LO     = 4'd1,
      OP_FL_HI     = 4'd2,
      OP_FL_COMMIT = 4'd3,
      OP_EE_LOAD   = 4'd4,
      OP_EE_COMMIT = 4'd5,
      OP_EE_BYTE   = 4'd6,
      OP_RD_FL     = 4'd7,
      OP_RD_EE     = 4'd8,
      OP_POLL      = 4'd9,
      OP_ERASE     = 4'd10
   } prog_op_e;
endpackage

// File: rtl/prog_busy_timer.sv
module prog_busy_timer #(
   parameter int FL_CYC = 4000,
   parameter int EE_CYC = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_fl,
   input  logic start_ee,
   output logic busy
);
   localparam int MAXC = (FL_CYC > EE_CYC) ? FL_CYC : EE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   if (FL_CYC < 1 || EE_CYC < 1) begin : g_bad_cyc
      $error("busy cycle counts must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (start_fl)  cnt <= CW'(FL_CYC);
      else if (start_ee)  cnt <= CW'(EE_CYC);
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == CW'(1)));
   assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAXC));
endmodule

// File: rtl/prog_flash_store.sv
module prog_flash_store #(
   parameter int OFF_BITS  = 5,
   parameter int PAGE_BITS = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld_lo,
   input  logic                          ld_hi,
   input  logic                          commit,
   input  logic                          erase,
   input  logic [OFF_BITS+PAGE_BITS-1:0] addr,
   input  logic [7:0]                    data,
   input  logic [OFF_BITS+PAGE_BITS-1:0] rd_addr,
   output logic [15:0]                   rd_word
);
   localparam int WORDS = 1 << OFF_BITS;
   localparam int PAGES = 1 << PAGE_BITS;

   if (OFF_BITS < 1 || PAGE_BITS < 1) begin : g_bad_geom
      $error("flash geometry fields must be at least one bit");
   end

   logic [OFF_BITS-1:0]  off;
   logic [PAGE_BITS-1:0] page;
   logic [WORDS-1:0]     lo_mask, hi_mask;
   logic [7:0]           lo_buf [WORDS];
   logic [7:0]           hi_buf [WORDS];
   logic [15:0]          col_rd [WORDS];

   assign off  = addr[OFF_BITS-1:0];
   assign page = addr[OFF_BITS+PAGE_BITS-1:OFF_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_mask <= '0;
         hi_mask <= '0;
      end else if (commit || erase) begin
         lo_mask <= '0;
         hi_mask <= '0;
      end else if (ld_lo) begin
         lo_mask[off] <= 1'b1;
      end else if (ld_hi && lo_mask[off]) begin
         hi_mask[off] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ld_lo) lo_buf[off] <= data;
      if (ld_hi && lo_mask[off]) hi_buf[off] <= data;
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_col
      logic [15:0] col [PAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) col[p] <= 16'hFFFF;
         end else if (erase) begin
            for (int p = 0; p < PAGES; p++) col[p] <= 16'hFFFF;
         end else if (commit) begin
            col[page] <= lo_mask[w] ? {(hi_mask[w] ? hi_buf[w] : 8'hFF), lo_buf[w]}
                                    : 16'hFFFF;
         end
      end
      assign col_rd[w] = col[rd_addr[OFF_BITS+PAGE_BITS-1:OFF_BITS]];
   end

   assign rd_word = col_rd[rd_addr[OFF_BITS-1:0]];

   assert_lo_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_mask & ~lo_mask) == '0);
   assert_fl_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (lo_mask == '0 && hi_mask == '0));
endmodule

// File: rtl/prog_eeprom_store.sv
module prog_eeprom_store #(
   parameter int OFF_BITS  = 2,
   parameter int PAGE_BITS = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld,
   input  logic                          commit,
   input  logic                          bytewr,
   input  logic                          erase,
   input  logic [OFF_BITS+PAGE_BITS-1:0] addr,
   input  logic [7:0]                    data,
   input  logic [OFF_BITS+PAGE_BITS-1:0] rd_addr,
   output logic [7:0]                    rd_byte
);
   localparam int BYTES = 1 << OFF_BITS;
   localparam int PAGES = 1 << PAGE_BITS;

   if (OFF_BITS < 1 || PAGE_BITS < 1) begin : g_bad_geom
      $error("eeprom geometry fields must be at least one bit");
   end

   logic [OFF_BITS-1:0]  off;
   logic [PAGE_BITS-1:0] page;
   logic [BYTES-1:0]     mask;
   logic [7:0]           stage [BYTES];
   logic [7:0]           col_rd [BYTES];

   assign off  = addr[OFF_BITS-1:0];
   assign page = addr[OFF_BITS+PAGE_BITS-1:OFF_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mask <= '0;
      else if (commit || erase)  mask <= '0;
      else if (ld)               mask[off] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (ld) stage[off] <= data;
   end

   for (genvar w = 0; w < BYTES; w++) begin : g_col
      logic [7:0] col [PAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) col[p] <= 8'hFF;
         end else if (erase) begin
            for (int p = 0; p < PAGES; p++) col[p] <= 8'hFF;
         end else if (commit && mask[w]) begin
            col[page] <= stage[w];
         end else if (bytewr && off == OFF_BITS'(w)) begin
            col[page] <= data;
         end
      end
      assign col_rd[w] = col[rd_addr[OFF_BITS+PAGE_BITS-1:OFF_BITS]];
   end

   assign rd_byte = col_rd[rd_addr[OFF_BITS-1:0]];

   assert_mask_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (mask == '0));
   assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({commit, bytewr, erase, ld}) <= 1);
endmodule

// File: rtl/prog_page_store.sv
module prog_page_store
   import prog_page_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int FL_OFF_BITS   = 5,
   parameter int FL_PAGE_BITS  = 6,
   parameter int EE_OFF_BITS   = 2,
   parameter int EE_PAGE_BITS  = 6,
   parameter int FL_BUSY_CYCLES = 4000,
   parameter int EE_BUSY_CYCLES = 3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   output logic              rsp_valid,
   output logic [7:0]        rsp_data,
   output logic              busy,
   output logic              busy_violation
);
   localparam int FL_AW = FL_OFF_BITS + FL_PAGE_BITS;
   localparam int EE_AW = EE_OFF_BITS + EE_PAGE_BITS;

   if (ADDR_W < FL_AW || ADDR_W < EE_AW) begin : g_bad_addr
      $error("ADDR_W too narrow for the configured arrays");
   end

   prog_op_e    op;
   logic        exec;
   logic        start_fl, start_ee;
   logic [15:0] fl_word;
   logic [7:0]  ee_byte;
   logic        rsp_v_q, viol_q;
   logic [7:0]  rsp_d_q;

   assign op   = prog_op_e'(cmd_op);
   assign exec = cmd_valid && !busy;

   assign start_fl = exec && (op == OP_FL_COMMIT || op == OP_ERASE);
   assign start_ee = exec && (op == OP_EE_COMMIT || op == OP_EE_BYTE);

   prog_busy_timer #(.FL_CYC(FL_BUSY_CYCLES), .EE_CYC(EE_BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_fl(start_fl), .start_ee(start_ee), .busy(busy)
   );

   prog_flash_store #(.OFF_BITS(FL_OFF_BITS), .PAGE_BITS(FL_PAGE_BITS)) u_flash (
      .clk(clk), .rst_n(rst_n),
      .ld_lo(exec && op == OP_FL_LO),
      .ld_hi(exec && op == OP_FL_HI),
      .commit(exec && op == OP_FL_COMMIT),
      .erase(exec && op == OP_ERASE),
      .addr(cmd_addr[FL_AW-1:0]),
      .data(cmd_data),
      .rd_addr(cmd_addr[FL_AW-1:0]),
      .rd_word(fl_word)
   );

   prog_eeprom_store #(.OFF_BITS(EE_OFF_BITS), .PAGE_BITS(EE_PAGE_BITS)) u_eeprom (
      .clk(clk), .rst_n(rst_n),
      .ld(exec && op == OP_EE_LOAD),
      .commit(exec && op == OP_EE_COMMIT),
      .bytewr(exec && op == OP_EE_BYTE),
      .erase(exec && op == OP_ERASE),
      .addr(cmd_addr[EE_AW-1:0]),
      .data(cmd_data),
      .rd_addr(cmd_addr[EE_AW-1:0]),
      .rd_byte(ee_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
         viol_q  <= 1'b0;
      end else begin
         viol_q  <= cmd_valid && busy && op != OP_POLL;
         rsp_v_q <= 1'b0;
         if (cmd_valid && op == OP_POLL) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= {7'd0, busy};
         end else if (exec && op == OP_RD_FL) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= cmd_data[0] ? fl_word[15:8] : fl_word[7:0];
         end else if (exec && op == OP_RD_EE) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= ee_byte;
         end
      end
   end

   assign rsp_valid      = rsp_v_q;
   assign rsp_data       = rsp_d_q;
   assign busy_violation = viol_q;

   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_fl || start_ee) |=> busy);
   assert_viol_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_violation |-> $past(busy));
   assert_rsp_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(cmd_valid));
   assert_viol_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_violation |-> !rsp_valid);
endmodule

// File: tb/prog_page_store_test.sv
module prog_page_store_test;
   localparam int FLB = 12;
   localparam int EEB = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [3:0] cmd_op = 4'd0;
   logic [15:0] cmd_addr = 16'd0;
   logic [7:0] cmd_data = 8'd0;
   logic rsp_valid, busy, busy_violation;
   logic [7:0] rsp_data;

   int checks = 0;
   int fails = 0;

   logic [15:0] fref [2048];
   logic [7:0]  eref [256];
   logic        lo_m [32];
   logic        hi_m [32];
   logic [7:0]  lob [32];
   logic [7:0]  hib [32];
   logic        ee_m [4];
   logic [7:0]  eeb [4];

   always #4 clk = ~clk;

   prog_page_store #(.FL_BUSY_CYCLES(FLB), .EE_BUSY_CYCLES(EEB)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .busy(busy), .busy_violation(busy_violation)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   function automatic void m_clear_flash_buf();
      for (int w = 0; w < 32; w++) begin lo_m[w] = 1'b0; hi_m[w] = 1'b0; end
   endfunction

   function automatic void m_clear_ee_buf();
      for (int i = 0; i < 4; i++) ee_m[i] = 1'b0;
   endfunction

   function automatic void m_erase();
      for (int i = 0; i < 2048; i++) fref[i] = 16'hFFFF;
      for (int i = 0; i < 256; i++) eref[i] = 8'hFF;
      m_clear_flash_buf();
      m_clear_ee_buf();
   endfunction

   function automatic void m_fl_commit(input int page);
      for (int w = 0; w < 32; w++)
         fref[page*32+w] = lo_m[w] ? {(hi_m[w] ? hib[w] : 8'hFF), lob[w]} : 16'hFFFF;
      m_clear_flash_buf();
   endfunction

   function automatic void m_ee_commit(input int page);
      for (int i = 0; i < 4; i++) if (ee_m[i]) eref[page*4+i] = eeb[i];
      m_clear_ee_buf();
   endfunction

   task automatic send(input logic [3:0] op, input int a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a[15:0]; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic fl_lo(input int wa, input logic [7:0] d);
      send(4'd1, wa, d);
      lo_m[wa%32] = 1'b1; lob[wa%32] = d;
   endtask

   task automatic fl_hi(input int wa, input logic [7:0] d);
      send(4'd2, wa, d);
      if (lo_m[wa%32]) begin hi_m[wa%32] = 1'b1; hib[wa%32] = d; end
   endtask

   task automatic fl_commit(input int page);
      send(4'd3, page*32, 8'h00);
      m_fl_commit(page);
      wait_idle();
   endtask

   task automatic ee_load(input int a, input logic [7:0] d);
      send(4'd4, a, d);
      ee_m[a%4] = 1'b1; eeb[a%4] = d;
   endtask

   task automatic ee_commit(input int page);
      send(4'd5, page*4, 8'h00);
      m_ee_commit(page);
      wait_idle();
   endtask

   task automatic ee_byte(input int a, input logic [7:0] d);
      send(4'd6, a, d);
      eref[a] = d;
      wait_idle();
   endtask

   task automatic rd_fl(input string req, input int wa, input bit hi);
      logic [15:0] e;
      send(4'd7, wa, {7'd0, hi});
      e = fref[wa];
      check(req, {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, (hi ? e[15:8] : e[7:0])});
   endtask

   task automatic rd_ee(input string req, input int a);
      send(4'd8, a, 8'h00);
      check(req, {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, eref[a]});
   endtask

   initial begin
      int n;
      void'($urandom(32'h1F2E3D4C));
      m_erase();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 rsp_valid", rsp_valid, 0);
      check("R1 busy_violation", busy_violation, 0);
      rd_fl("R1 flash erased", 37, 1'b1);
      rd_ee("R1 eeprom erased", 200);

      // R2 high before low is ignored; R3 unloaded and half-loaded words
      fl_hi(2*32+3, 8'hA5);
      fl_lo(2*32+4, 8'h34);
      fl_hi(2*32+4, 8'h12);
      fl_lo(2*32+6, 8'h77);
      fl_commit(2);
      rd_fl("R2 high ignored hi", 2*32+3, 1'b1);
      rd_fl("R2 high ignored lo", 2*32+3, 1'b0);
      rd_fl("R2 word high", 2*32+4, 1'b1);
      rd_fl("R2 word low", 2*32+4, 1'b0);
      rd_fl("R3 high default", 2*32+6, 1'b1);
      rd_fl("R3 low staged", 2*32+6, 1'b0);
      // R3 recommit of page fills old words with erased value
      fl_lo(2*32+9, 8'h99);
      fl_commit(2);
      rd_fl("R3 old word refilled", 2*32+4, 1'b0);
      rd_fl("R3 new word", 2*32+9, 1'b0);

      // R4 masked eeprom page commit
      for (int i = 0; i < 4; i++) ee_byte(4+i, 8'h10 + 8'(i));
      ee_load(6, 8'hC3);
      ee_commit(1);
      for (int i = 0; i < 4; i++) rd_ee("R4 masked commit", 4+i);
      ee_commit(1);
      rd_ee("R4 mask cleared", 6);

      // R5 byte write replaces bits
      ee_byte(30, 8'h0F);
      ee_byte(30, 8'hF0);
      rd_ee("R5 full replace", 30);

      // R7 poll idle, R8 busy length flash, R9 ignored while busy
      send(4'd9, 0, 8'h00);
      check("R7 poll idle", {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, 8'h00});
      send(4'd3, 5*32, 8'h00);
      m_fl_commit(5);
      send(4'd9, 0, 8'h00);
      check("R7 poll busy", {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, 8'h01});
      send(4'd6, 30, 8'h55);
      check("R9 violation flag", busy_violation, 1);
      check("R9 no response", rsp_valid, 0);
      wait_idle();
      rd_ee("R9 write dropped", 30);
      send(4'd3, 7*32, 8'h00);
      m_fl_commit(7);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check("R8 flash busy length", n, FLB);
      send(4'd6, 40, 8'h3C);
      eref[40] = 8'h3C;
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check("R8 eeprom busy length", n, EEB);
      check("R9 no violation when idle", busy_violation, 0);

      // R6 random traffic on a few pages
      for (int it = 0; it < 400; it++) begin
         int pg, k;
         k = $urandom % 9;
         pg = $urandom % 4;
         case (k)
            0, 1: fl_lo(pg*32 + ($urandom % 32), 8'($urandom));
            2:    fl_hi(pg*32 + ($urandom % 32), 8'($urandom));
            3:    fl_commit(pg);
            4:    ee_load($urandom % 16, 8'($urandom));
            5:    ee_commit(pg);
            6:    ee_byte($urandom % 16, 8'($urandom));
            7:    rd_fl("R6 random flash read", pg*32 + ($urandom % 32), 1'($urandom));
            default: rd_ee("R6 random eeprom read", $urandom % 16);
         endcase
      end
      for (int w = 0; w < 4*32; w += 5) rd_fl("R6 sweep flash", w, 1'b0);
      for (int a = 0; a < 16; a++) rd_ee("R6 sweep eeprom", a);

      // R10 chip erase
      send(4'd10, 0, 8'h00);
      m_erase();
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check("R10 erase busy", n, FLB);
      rd_fl("R10 flash erased", 2*32+4, 1'b0);
      rd_fl("R10 flash erased hi", 2*32+9, 1'b1);
      rd_ee("R10 eeprom erased", 5);
      rd_ee("R10 eeprom erased 2", 30);
      ee_commit(1);
      rd_ee("R10 mask cleared", 6);

      summary();
   end
endmodule